// File: doc/BRIEF.md
# Two-Trace Past-Time Security Monitor

This block watches two executions of the same design that run side by side, cycle for cycle, and decides at run time whether a security property over the pair has been broken. An outside harness compares the two executions every cycle and hands the monitor a set of per-pair predicates: whether the inputs matched, whether the outputs matched, whether a chosen destination signal matched, whether all state other than a chosen source matched, and a fault-present flag for each execution. A strobe marks the cycles that count as trace steps.

Inside, four kinds of past-time operator are evaluated: previous-step, always-so-far, at-least-once, and since. Each instance keeps one flip-flop of state, so the cost does not depend on trace length. The operator outputs are combined into two fixed checks. The first is noninterference: the fault-free reference execution and the other execution saw identical inputs, yet their outputs split. The second is secure information flow: the executions began identical apart from the source, saw identical attacker inputs, yet the destination split. A mode input picks the check that is active. A violation latches until the next start pulse, which also begins a new pair of traces.

Top module: `hyper_mon_top`

## Requirements
- R1: After synchronous reset `violation` is 0, and every operator is at its initial value, so the next strobed cycle counts as step 0.
- R2: A `start` pulse clears `violation` on the next edge and reinitialises every operator, so the next strobed cycle counts as step 0. A strobe on the same cycle as `start` is ignored.
- R3: On cycles with `step_valid` low, the predicate and mode inputs have no effect: neither `violation` nor any operator state changes.
- R4: With `mode` = 0 (noninterference), a strobed step raises `violation` when `in_eq` has been 1 at every step since step 0, the reference trace's fault flag has been 0 at every step since step 0, and `out_eq` has been 0 at one or more steps up to and including this one.
- R5: In noninterference mode, a single step with `in_eq` = 0 stops any later step from raising `violation` until the next start.
- R6: The reference trace is trace A (`fault_a`) when parameter `FAULT_REF_B` is 0, which is the default. A fault on the reference trace at any step stops noninterference violations until the next start. A fault on the other trace has no effect.
- R7: With `mode` = 1 (information flow), a strobed step raises `violation` when `nsrc_eq` was 1 at step 0, `in_eq` has been 1 at every step, and `dst_eq` has been 0 at one or more steps up to and including this one.
- R8: In information-flow mode only step 0's `nsrc_eq` matters. A 0 there stops violations until the next start, and `nsrc_eq` values at later steps have no effect.
- R9: Once set, `violation` stays 1, whatever the predicates or mode do, until a `start` pulse.
- R10: Every operator tracks its predicates on each strobed step whichever mode is selected, and each step is judged under the `mode` value present on that step.
- R11: `violation` rises on the clock edge that ends the strobed step whose check fails. It has a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new trace pair; clears all operator state and the violation |
| step_valid | input | 1 | Marks a cycle as a trace step |
| mode | input | 1 | 0 = noninterference, 1 = information flow |
| in_eq | input | 1 | Inputs of the two traces are equal this step |
| out_eq | input | 1 | Outputs of the two traces are equal this step |
| dst_eq | input | 1 | Destination values are equal this step |
| nsrc_eq | input | 1 | All state except the source is equal this step |
| fault_a | input | 1 | Fault present in trace A this step |
| fault_b | input | 1 | Fault present in trace B this step |
| violation | output | 1 | Sticky property violation flag |

## Verification
The hardest situations to reach are the late verdicts. One is a violation that depends on a step-0 condition several steps back. The other is a long run of equal inputs and a fault-free reference broken by a single mismatch. Uniformly random predicates almost never keep `in_eq` high for long, so the random stimulus draws the equality predicates mostly high and the fault flags mostly low, with random gaps in the strobe and random mode changes. Directed sequences then place the first difference at a chosen step, put a `nsrc_eq` mismatch only at step 0 or only later, and fault each trace in turn.

// File: rtl/hyper_mon_pkg.sv
package hyper_mon_pkg;

    typedef enum logic [1:0] {
        OP_PREV = 2'd0,
        OP_HIST = 2'd1,
        OP_ONCE = 2'd2
    } unary_op_e;

    typedef enum logic {
        CHK_NONINTERF = 1'b0,
        CHK_INFOFLOW  = 1'b1
    } check_mode_e;

    typedef struct packed {
        logic in_eq;
        logic out_eq;
        logic dst_eq;
        logic nsrc_eq;
        logic fault_ref;
    } pair_pred_t;

    typedef struct packed {
        logic not_first;
        logic inputs_hist;
        logic ref_clean;
        logic init_match;
        logic out_diff_once;
        logic dst_diff_once;
    } op_vals_t;

    function automatic logic op_init(input unary_op_e k);
        return (k == OP_HIST);
    endfunction

    function automatic logic op_now(input unary_op_e k, input logic st, input logic a);
        case (k)
            OP_PREV: return st;
            OP_HIST: return st & a;
            default: return st | a;
        endcase
    endfunction

    function automatic logic op_next(input unary_op_e k, input logic st, input logic a);
        if (k == OP_PREV) return a;
        return op_now(k, st, a);
    endfunction

    function automatic logic since_now(input logic st, input logic a, input logic b);
        return b | (a & st);
    endfunction

endpackage

// File: rtl/ptl_unary.sv
module ptl_unary
    import hyper_mon_pkg::*;
#(
    parameter unary_op_e KIND = OP_HIST
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic adv,
    input  logic a,
    output logic now
);
    logic st_q;

    always_ff @(posedge clk) begin
        if (rst || restart) st_q <= op_init(KIND);
        else if (adv)       st_q <= op_next(KIND, st_q, a);
    end

    assign now = op_now(KIND, st_q, a);

    generate
        if (KIND == OP_HIST) begin : g_hist
            assert_hist_never_recovers_R4: assert property (@(posedge clk) disable iff (rst)
                (!restart && !st_q) |=> !st_q);
        end else if (KIND == OP_ONCE) begin : g_once
            assert_once_never_forgets_R9: assert property (@(posedge clk) disable iff (rst)
                (!restart && st_q) |=> st_q);
        end else begin : g_prev
            assert_prev_holds_last_R10: assert property (@(posedge clk) disable iff (rst)
                (adv && !restart) |=> (st_q == $past(a)));
        end
    endgenerate

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!adv && !restart) |=> $stable(st_q));

endmodule

// File: rtl/ptl_since.sv
module ptl_since
    import hyper_mon_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic adv,
    input  logic a,
    input  logic b,
    output logic now
);
    logic st_q;

    always_ff @(posedge clk) begin
        if (rst || restart) st_q <= 1'b0;
        else if (adv)       st_q <= since_now(st_q, a, b);
    end

    assign now = since_now(st_q, a, b);

    assert_since_broken_R6: assert property (@(posedge clk) disable iff (rst)
        (adv && !restart && !a && !b) |=> !st_q);

    assert_since_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (!adv && !restart) |=> $stable(st_q));

endmodule

// File: rtl/hyper_mon_top.sv
module hyper_mon_top
    import hyper_mon_pkg::*;
#(
    parameter bit FAULT_REF_B = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic step_valid,
    input  logic mode,
    input  logic in_eq,
    input  logic out_eq,
    input  logic dst_eq,
    input  logic nsrc_eq,
    input  logic fault_a,
    input  logic fault_b,
    output logic violation
);
    pair_pred_t  pred;
    op_vals_t    ov;
    check_mode_e sel;
    logic        adv;
    logic        ni_hit;
    logic        if_hit;
    logic        hit;
    logic        viol_q;

    generate
        if (FAULT_REF_B) begin : g_ref_b
            assign pred.fault_ref = fault_b;
        end else begin : g_ref_a
            assign pred.fault_ref = fault_a;
        end
    endgenerate

    assign pred.in_eq   = in_eq;
    assign pred.out_eq  = out_eq;
    assign pred.dst_eq  = dst_eq;
    assign pred.nsrc_eq = nsrc_eq;
    assign sel = check_mode_e'(mode);
    assign adv = step_valid & ~start;

    ptl_unary #(.KIND(OP_PREV)) u_first (
        .clk(clk), .rst(rst), .restart(start), .adv(adv),
        .a(1'b1), .now(ov.not_first));

    ptl_unary #(.KIND(OP_HIST)) u_inputs (
        .clk(clk), .rst(rst), .restart(start), .adv(adv),
        .a(pred.in_eq), .now(ov.inputs_hist));

    ptl_since u_clean (
        .clk(clk), .rst(rst), .restart(start), .adv(adv),
        .a(~pred.fault_ref), .b(~pred.fault_ref & ~ov.not_first),
        .now(ov.ref_clean));

    ptl_unary #(.KIND(OP_HIST)) u_init (
        .clk(clk), .rst(rst), .restart(start), .adv(adv),
        .a(pred.nsrc_eq | ov.not_first), .now(ov.init_match));

    ptl_unary #(.KIND(OP_ONCE)) u_outdiff (
        .clk(clk), .rst(rst), .restart(start), .adv(adv),
        .a(~pred.out_eq), .now(ov.out_diff_once));

    ptl_unary #(.KIND(OP_ONCE)) u_dstdiff (
        .clk(clk), .rst(rst), .restart(start), .adv(adv),
        .a(~pred.dst_eq), .now(ov.dst_diff_once));

    assign ni_hit = ov.inputs_hist & ov.ref_clean & ov.out_diff_once;
    assign if_hit = ov.init_match & ov.inputs_hist & ov.dst_diff_once;
    assign hit    = (sel == CHK_INFOFLOW) ? if_hit : ni_hit;

    always_ff @(posedge clk) begin
        if (rst || start) viol_q <= 1'b0;
        else if (adv && hit) viol_q <= 1'b1;
    end

    assign violation = viol_q;

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> !violation);

    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (violation && !start) |=> violation);

    assert_idle_no_change_R3: assert property (@(posedge clk) disable iff (rst)
        (!step_valid && !start) |=> $stable(violation));

    assert_ni_input_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (adv && !mode && !in_eq && !violation) |=> !violation);

    assert_if_dst_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (adv && mode && !ov.dst_diff_once && !violation) |=> !violation);

endmodule

// File: tb/sim_hyper_mon_top.sv
module sim_hyper_mon_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst, start, step_valid, mode;
    logic in_eq, out_eq, dst_eq, nsrc_eq, fault_a, fault_b;
    logic violation;

    int n_checks = 0;
    int n_fail   = 0;

    // reference model state
    bit m_first, m_inh, m_clean, m_init, m_od, m_dd, m_viol;

    always #(CLK_PERIOD/2) clk = ~clk;

    hyper_mon_top u0 (
        .clk(clk), .rst(rst), .start(start), .step_valid(step_valid), .mode(mode),
        .in_eq(in_eq), .out_eq(out_eq), .dst_eq(dst_eq), .nsrc_eq(nsrc_eq),
        .fault_a(fault_a), .fault_b(fault_b), .violation(violation));

    function automatic void model_clear();
        m_first = 1; m_inh = 1; m_clean = 1; m_init = 1; m_od = 0; m_dd = 0; m_viol = 0;
    endfunction

    function automatic void model_step(bit v, bit st, bit md, bit ie, bit oe, bit de,
                                       bit ne, bit fa);
        bit inh, cl, ini, od, dd, hit;
        if (st) begin
            model_clear();
            return;
        end
        if (!v) return;
        inh = m_inh & ie;
        cl  = m_clean & !fa;
        ini = m_first ? (m_init & ne) : m_init;
        od  = m_od | !oe;
        dd  = m_dd | !de;
        hit = md ? (ini & inh & dd) : (inh & cl & od);
        m_viol  = m_viol | hit;
        m_inh = inh; m_clean = cl; m_init = ini; m_od = od; m_dd = dd; m_first = 0;
    endfunction

    task automatic check(string req, bit exp);
        n_checks++;
        if (violation !== exp) begin
            n_fail++;
            $display("FAIL %s: violation=%b expected=%b at %0t", req, violation, exp, $time);
        end
    endtask

    // drive at negedge, advance one edge, sample after it
    task automatic cyc(bit st, bit v, bit md, bit ie, bit oe, bit de, bit ne, bit fa, bit fb);
        start = st; step_valid = v; mode = md; in_eq = ie; out_eq = oe;
        dst_eq = de; nsrc_eq = ne; fault_a = fa; fault_b = fb;
        model_step(v, st, md, ie, oe, de, ne, fa);
        @(posedge clk); #1;
        start = 0; step_valid = 0;
    endtask

    task automatic go(string req, bit st, bit v, bit md, bit ie, bit oe, bit de, bit ne,
                      bit fa, bit fb, bit exp);
        cyc(st, v, md, ie, oe, de, ne, fa, fb);
        check(req, exp);
        if (exp != m_viol) $display("model mismatch note for %s", req);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 60000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        model_clear();
        rst = 1; start = 0; step_valid = 0; mode = 0;
        in_eq = 1; out_eq = 1; dst_eq = 1; nsrc_eq = 1; fault_a = 0; fault_b = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        check("R1 reset", 0);

        // R4 + R11: outputs differ at step 2
        go("R4 eq step0", 1, 0, 0, 1,1,1,1, 0,0, 0);
        go("R4 eq step0", 0, 1, 0, 1,1,1,1, 0,0, 0);
        go("R4 eq step1", 0, 1, 0, 1,1,1,1, 0,0, 0);
        go("R11 out differ -> next edge", 0, 1, 0, 1,0,1,1, 0,0, 1);
        // R9 sticky despite mismatched inputs and mode change
        go("R9 sticky", 0, 1, 1, 0,1,1,0, 1,1, 1);
        go("R9 sticky idle", 0, 0, 0, 0,0,0,0, 1,1, 1);
        // R2 start clears; strobe with start ignored
        go("R2 start clears", 1, 1, 0, 1,0,1,1, 0,0, 0);
        go("R2 step0 after start", 0, 1, 0, 1,1,1,1, 0,0, 0);
        // R5 input mismatch earlier blocks later output difference
        go("R5 inputs differ", 0, 1, 0, 0,1,1,1, 0,0, 0);
        go("R5 later out diff", 0, 1, 0, 1,0,1,1, 0,0, 0);
        // R3 invalid cycles ignored
        go("R3 idle setup", 1, 0, 0, 1,1,1,1, 0,0, 0);
        go("R3 idle ignored", 0, 0, 0, 0,1,1,1, 1,0, 0);
        go("R3 idle ignored", 0, 0, 0, 1,1,1,0, 1,0, 0);
        go("R3 valid out diff", 0, 1, 0, 1,0,1,1, 0,0, 1);
        // R6 fault in trace B harmless, fault in trace A suppresses
        go("R6 setup", 1, 0, 0, 1,1,1,1, 0,0, 0);
        go("R6 fault_b only", 0, 1, 0, 1,0,1,1, 0,1, 1);
        go("R6 setup", 1, 0, 0, 1,1,1,1, 0,0, 0);
        go("R6 fault_a step0", 0, 1, 0, 1,1,1,1, 1,0, 0);
        go("R6 later out diff", 0, 1, 0, 1,0,1,1, 0,0, 0);
        go("R6 later out diff", 0, 1, 0, 1,0,1,1, 0,0, 0);
        // R7 information flow
        go("R7 setup", 1, 0, 1, 1,1,1,1, 0,0, 0);
        go("R7 step0", 0, 1, 1, 1,1,1,1, 0,0, 0);
        go("R8 later nsrc ignored", 0, 1, 1, 1,1,1,0, 0,0, 0);
        go("R7 dst differs", 0, 1, 1, 1,1,0,0, 0,0, 1);
        // R8 step0 nsrc mismatch blocks
        go("R8 setup", 1, 0, 1, 1,1,1,1, 0,0, 0);
        go("R8 step0 nsrc differs", 0, 1, 1, 1,1,1,0, 0,0, 0);
        go("R8 dst differs blocked", 0, 1, 1, 1,1,0,1, 0,0, 0);
        // R10 ops track while other mode selected; verdict under current mode
        go("R10 setup", 1, 0, 0, 1,1,1,1, 0,0, 0);
        go("R10 dst diff in NI mode", 0, 1, 0, 1,1,0,1, 0,0, 0);
        go("R10 switch to IF", 0, 1, 1, 1,1,1,1, 0,0, 1);

        // random phase, checked against model
        begin
            void'($urandom(32'h5EED_1234));
            for (int t = 0; t < 4000; t++) begin
                bit st, v, md, ie, oe, de, ne, fa, fb;
                st = ($urandom_range(0, 29) == 0);
                v  = ($urandom_range(0, 3) != 0);
                md = ($urandom_range(0, 7) == 0) ? !mode : mode;
                ie = ($urandom_range(0, 24) != 0);
                oe = ($urandom_range(0, 9) != 0);
                de = ($urandom_range(0, 9) != 0);
                ne = ($urandom_range(0, 11) != 0);
                fa = ($urandom_range(0, 30) == 0);
                fb = ($urandom_range(0, 5) == 0);
                cyc(st, v, md, ie, oe, de, ne, fa, fb);
                mode = md;
                check("R4/R7 random vs model", m_viol);
                @(negedge clk);
            end
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule